// File: doc/BRIEF.md
# PRBS Error Detector with Sync

This block receives a serial bit stream, one bit per clock. It locks a local reference register onto an incoming pseudo-random binary sequence and then predicts every following bit. Once sync is held, each received bit is checked against the predicted bit. A mismatch is classed as an omission when a 1 was expected and a 0 arrived. It is classed as an insertion when a 0 was expected and a 1 arrived. Saturating counters collect omissions, insertions, their total and the number of checked bits. A latch strobe copies the live counts into hold registers, and the outputs read from those hold registers.

To acquire sync, the detector first loads n received bits straight into its reference register. It then free-runs and checks a short verification run of bits, which must hold no mismatch. In sync, it judges the error rate over fixed windows of bits. When a window holds more errors than the selected decade threshold allows, sync is dropped and acquisition starts again. The threshold is either a fixed 10^-k rate or an automatic coarse setting.

Top module: `prbs_err_det`

## Requirements
- R1: `orderSel` codes 0..6 select n = 7, 9, 11, 15, 20, 23, 31 with feedback tap m = 6, 5, 9, 14, 3, 18, 28. The expected sequence obeys b[k] = b[k-n] xor b[k-m]. Code 7 behaves as code 0. A clean stream of any order, once locked, gives no errors.
- R2: After reset or a restart, the first n bits are loaded and the next VERIFY_LEN bits are checked. If none of those bits mismatch, `syncOk` is high in the cycle after the last verification bit.
- R3: A mismatch during verification restarts acquisition at once, and a new n-bit load follows.
- R4: An in-sync mismatch with expected 1 and received 0 counts as an omission. One with expected 0 and received 1 counts as an insertion. Either kind also counts toward the total.
- R5: `errCount` shows the latched omission count for `errMode` 0, the insertion count for 1, and the total for 2 or 3. A change of `errMode` shows at the output in the same cycle.
- R6: Bits received while out of sync never change any counter.
- R7: In sync, bits are judged in windows of WINDOW bits. Let `thrSel` = c be in 0..6. When the window's error total exceeds floor(WINDOW / 10^(c+2)), sync is dropped after the window's last bit. Otherwise a new window starts.
- R8: `thrSel` = 7 selects automatic mode, with a limit of floor(WINDOW / 4) errors per window.
- R9: All counters saturate at 2^CNT_W - 1 and do not wrap.
- R10: `latchCnt` captures the counts of all bits received before that cycle. `clearCnt` zeroes the live counts, and the bit received in the same cycle is not counted. When both are asserted in one cycle, the latch takes the pre-clear values.
- R11: `bitCount` shows the latched number of bits compared while in sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Received serial bit |
| orderSel | input | 3 | Sequence order code |
| thrSel | input | 3 | Sync-loss threshold code |
| errMode | input | 2 | Error counter selection |
| clearCnt | input | 1 | Zero live counters |
| latchCnt | input | 1 | Copy live counters to outputs |
| syncOk | output | 1 | Reference locked to the stream |
| errCount | output | CNT_W | Latched error count for the selected mode |
| bitCount | output | CNT_W | Latched count of compared bits |

## Verification
The counter clear and the counter snapshot can land in the same cycle. That cycle's received bit may also be a mismatch, so three updates meet in one edge. The bench raises both strobes together on a deliberately flipped bit. The first snapshot must hold the pre-clear totals. A later snapshot must exclude that flipped bit and every bit before it. A second overlap is the window boundary, where the end-of-window decision takes the final bit's error into account. Error counts of exactly the limit and the limit plus one are placed against several thresholds.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;

  typedef enum logic [1:0] {
    SYNC_HUNT   = 2'd0,
    SYNC_VERIFY = 2'd1,
    SYNC_LOCKED = 2'd2
  } syncState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBit;   // shift received bit into reference
    logic countBit;  // compare result is counted
  } dpStrobe_t;

  // Highest bit position (n-1) of the reference for an order code
  function automatic logic [4:0] topBit(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd8;
      3'd2:    return 5'd10;
      3'd3:    return 5'd14;
      3'd4:    return 5'd19;
      3'd5:    return 5'd22;
      3'd6:    return 5'd30;
      default: return 5'd6;
    endcase
  endfunction

  // Feedback tap position (m-1) for an order code
  function automatic logic [4:0] tapBit(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd4;
      3'd2:    return 5'd8;
      3'd3:    return 5'd13;
      3'd4:    return 5'd2;
      3'd5:    return 5'd17;
      3'd6:    return 5'd27;
      default: return 5'd5;
    endcase
  endfunction

endpackage

// File: rtl/prbs_det_datapath.sv
module prbs_det_datapath
  import prbs_det_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic [2:0]       orderSel,
  input  logic [1:0]       errMode,
  input  logic             clearCnt,
  input  logic             latchCnt,
  input  dpStrobe_t        strobe,
  output logic             errBit,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [30:0]      refReg;
  logic             expBit;
  logic [CNT_W-1:0] omitLive, insLive, totLive, bitLive;
  logic [CNT_W-1:0] omitHold, insHold, totHold, bitHold;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign expBit = refReg[topBit(orderSel)] ^ refReg[tapBit(orderSel)];
  assign errBit = expBit ^ dataIn;

  // Reference register: loads received bits while hunting, free-runs otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refReg <= '0;
    else if (strobe.loadBit) refReg <= {refReg[29:0], dataIn};
    else refReg <= {refReg[29:0], expBit};
  end

  // Live counters; clear wins over counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      omitLive <= '0; insLive <= '0; totLive <= '0; bitLive <= '0;
    end else if (clearCnt) begin
      omitLive <= '0; insLive <= '0; totLive <= '0; bitLive <= '0;
    end else if (strobe.countBit) begin
      bitLive <= satInc(bitLive);
      if (errBit && expBit)  omitLive <= satInc(omitLive);
      if (errBit && !expBit) insLive  <= satInc(insLive);
      if (errBit)            totLive  <= satInc(totLive);
    end
  end

  // Snapshot registers take pre-update values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      omitHold <= '0; insHold <= '0; totHold <= '0; bitHold <= '0;
    end else if (latchCnt) begin
      omitHold <= omitLive; insHold <= insLive;
      totHold  <= totLive;  bitHold <= bitLive;
    end
  end

  always_comb begin
    case (errMode)
      2'd0:    errCount = omitHold;
      2'd1:    errCount = insHold;
      default: errCount = totHold;
    endcase
  end
  assign bitCount = bitHold;

  // R6: nothing moves when not counting and not clearing
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countBit && !clearCnt) |=> ($stable(totLive) && $stable(bitLive)));

  // R9: counters never step backwards except on clear
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!clearCnt) |=> (bitLive >= $past(bitLive) && totLive >= $past(totLive)));

  // R4: total equals the sum of its two kinds while nothing is saturated
  assert_split_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    (omitLive != CNT_MAX && insLive != CNT_MAX && totLive != CNT_MAX) |->
      ({1'b0, omitLive} + {1'b0, insLive} == {1'b0, totLive}));

  // R10: snapshot holds the value before the strobe edge
  assert_latch_prior_R10: assert property (@(posedge clk) disable iff (!rstN)
    latchCnt |=> (bitHold == $past(bitLive) && totHold == $past(totLive)));

endmodule

// File: rtl/prbs_det_control.sv
module prbs_det_control
  import prbs_det_pkg::*;
#(
  parameter int WINDOW     = 1024,
  parameter int VERIFY_LEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] orderSel,
  input  logic [2:0] thrSel,
  input  logic       errBit,
  output dpStrobe_t  strobe,
  output logic       syncOk
);

  localparam int SPAN = (WINDOW > VERIFY_LEN) ? WINDOW : VERIFY_LEN;
  localparam int PH_W = $clog2(SPAN) + 1;
  localparam logic [PH_W-1:0] WIN_LAST    = PH_W'(WINDOW - 1);
  localparam logic [PH_W-1:0] VERIFY_LAST = PH_W'(VERIFY_LEN - 1);

  syncState_t      state;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] winErr;
  logic [PH_W-1:0] winTotal;
  logic [PH_W-1:0] limVal;
  logic [PH_W-1:0] loadLast;

  function automatic logic [PH_W-1:0] lossLimit(input logic [2:0] t);
    int v;
    case (t)
      3'd0:    v = WINDOW / 100;
      3'd1:    v = WINDOW / 1000;
      3'd2:    v = WINDOW / 10000;
      3'd3:    v = WINDOW / 100000;
      3'd4:    v = WINDOW / 1000000;
      3'd5:    v = WINDOW / 10000000;
      3'd6:    v = WINDOW / 100000000;
      default: v = WINDOW / 4;
    endcase
    return PH_W'(v);
  endfunction

  assign limVal   = lossLimit(thrSel);
  assign loadLast = PH_W'(topBit(orderSel));
  assign winTotal = winErr + PH_W'(errBit);

  always_comb begin
    strobe.loadBit  = (state == SYNC_HUNT);
    strobe.countBit = (state == SYNC_LOCKED);
  end
  assign syncOk = (state == SYNC_LOCKED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SYNC_HUNT; phase <= '0; winErr <= '0;
    end else begin
      case (state)
        SYNC_HUNT: begin
          if (phase == loadLast) begin
            state <= SYNC_VERIFY; phase <= '0;
          end else phase <= phase + 1'b1;
        end
        SYNC_VERIFY: begin
          if (errBit) begin
            state <= SYNC_HUNT; phase <= '0;
          end else if (phase == VERIFY_LAST) begin
            state <= SYNC_LOCKED; phase <= '0; winErr <= '0;
          end else phase <= phase + 1'b1;
        end
        SYNC_LOCKED: begin
          if (phase == WIN_LAST) begin
            phase <= '0; winErr <= '0;
            if (winTotal > limVal) state <= SYNC_HUNT;
          end else begin
            phase <= phase + 1'b1; winErr <= winTotal;
          end
        end
        default: begin
          state <= SYNC_HUNT; phase <= '0;
        end
      endcase
    end
  end

  // R2: lock is only entered from a clean verification bit
  assert_lock_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOk) |-> ($past(state == SYNC_VERIFY) && $past(!errBit)));

  // R3: a mismatch while verifying goes back to hunting
  assert_verify_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == SYNC_VERIFY && errBit) |=> (state == SYNC_HUNT));

  // R7: sync can only drop at a window boundary
  assert_window_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncOk) |-> ($past(phase) == WIN_LAST));

  // R6: counting strobe never fires before verification completes
  assert_count_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != SYNC_LOCKED) |=> !(strobe.countBit && $past(state == SYNC_HUNT)));

endmodule

// File: rtl/prbs_err_det.sv
module prbs_err_det
  import prbs_det_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int WINDOW     = 1024,
  parameter int VERIFY_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic [2:0]       orderSel,
  input  logic [2:0]       thrSel,
  input  logic [1:0]       errMode,
  input  logic             clearCnt,
  input  logic             latchCnt,
  output logic             syncOk,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount
);

  dpStrobe_t strobe;
  logic      errBit;

  prbs_det_control #(.WINDOW(WINDOW), .VERIFY_LEN(VERIFY_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .orderSel(orderSel), .thrSel(thrSel),
    .errBit(errBit), .strobe(strobe), .syncOk(syncOk)
  );

  prbs_det_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .orderSel(orderSel),
    .errMode(errMode), .clearCnt(clearCnt), .latchCnt(latchCnt),
    .strobe(strobe), .errBit(errBit), .errCount(errCount), .bitCount(bitCount)
  );

endmodule

// File: tb/prbs_err_det_test.sv
module prbs_err_det_test;

  localparam int CW = 12;
  localparam int WIN = 1024;
  localparam int VL = 64;

  logic clk = 0;
  logic rstN = 0;
  logic dataIn = 0;
  logic [2:0] orderSel = 0;
  logic [2:0] thrSel = 7;
  logic [1:0] errMode = 2;
  logic clearCnt = 0;
  logic latchCnt = 0;
  logic syncOk;
  logic [CW-1:0] errCount, bitCount;

  int tests = 0;
  int fails = 0;
  int idx = 0;
  logic [30:0] bhist;

  always #2.5 clk = ~clk;

  prbs_err_det #(.CNT_W(CW), .WINDOW(WIN), .VERIFY_LEN(VL)) uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .orderSel(orderSel),
    .thrSel(thrSel), .errMode(errMode), .clearCnt(clearCnt),
    .latchCnt(latchCnt), .syncOk(syncOk), .errCount(errCount), .bitCount(bitCount)
  );

  function automatic int ordN(input logic [2:0] c);
    case (c)
      3'd1: return 9; 3'd2: return 11; 3'd3: return 15; 3'd4: return 20;
      3'd5: return 23; 3'd6: return 31; default: return 7;
    endcase
  endfunction

  function automatic int ordM(input logic [2:0] c);
    case (c)
      3'd1: return 5; 3'd2: return 9; 3'd3: return 14; 3'd4: return 3;
      3'd5: return 18; 3'd6: return 28; default: return 6;
    endcase
  endfunction

  function automatic logic peekBit();
    return bhist[ordN(orderSel)-1] ^ bhist[ordM(orderSel)-1];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Drive one bit at a negedge; the following posedge samples it
  task automatic step(input logic flip, input logic clr = 1'b0, input logic lat = 1'b0);
    logic b;
    b = peekBit();
    dataIn = b ^ flip;
    clearCnt = clr;
    latchCnt = lat;
    bhist = {bhist[29:0], b};
    idx++;
    @(negedge clk);
    clearCnt = 0;
    latchCnt = 0;
  endtask

  task automatic runTo(input int upTo);
    while (idx < upTo) step(1'b0);
  endtask

  task automatic doReset(input logic [2:0] ord, input logic [2:0] thr);
    rstN = 0;
    orderSel = ord;
    thrSel = thr;
    errMode = 2;
    bhist = '1;
    idx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic testReset();
    doReset(3'd0, 3'd7);
    chk("R6 reset sync", syncOk, 0);
    chk("R11 reset bits", bitCount, 0);
    chk("R5 reset errs", errCount, 0);
  endtask

  // R1 R2: every order locks on time and stays clean
  task automatic testOrders();
    for (int c = 0; c < 7; c++) begin
      int n;
      doReset(3'(c), 3'd4);
      n = ordN(3'(c));
      runTo(n + VL - 1);
      chk("R2 before lock", syncOk, 0);
      step(1'b0);
      chk("R2 lock time", syncOk, 1);
      runTo(n + VL + 1100);
      step(1'b0, 1'b0, 1'b1);
      chk("R1 clean errors", errCount, 0);
      chk("R11 bit count", bitCount, 1100);
      chk("R1 still locked", syncOk, 1);
    end
  endtask

  // R3 R6: verify error restarts; it is not counted
  task automatic testVerifyAbort();
    doReset(3'd0, 3'd7);
    runTo(17);
    step(1'b1);
    runTo(88);
    chk("R3 no early lock", syncOk, 0);
    step(1'b0);
    chk("R3 relock time", syncOk, 1);
    runTo(120);
    step(1'b0, 1'b0, 1'b1);
    chk("R6 verify error uncounted", errCount, 0);
    chk("R11 bits after relock", bitCount, 120 - 89);
  endtask

  // R4 R5: omission and insertion split, mode selection
  task automatic testClassify();
    int om = 0;
    int ins = 0;
    doReset(3'd0, 3'd7);
    runTo(71);
    while (idx < 300) begin
      logic b;
      b = peekBit();
      if (idx >= 80 && b && om < 5) begin om++; step(1'b1); end
      else if (idx >= 80 && !b && ins < 3) begin ins++; step(1'b1); end
      else step(1'b0);
    end
    step(1'b0, 1'b0, 1'b1);
    errMode = 0; #1 chk("R4 omissions", errCount, 5);
    errMode = 1; #1 chk("R4 insertions", errCount, 3);
    errMode = 2; #1 chk("R5 total", errCount, 8);
    errMode = 3; #1 chk("R5 mode3 total", errCount, 8);
    errMode = 2;
    chk("R11 classify bits", bitCount, 229);
  endtask

  // R7 R8: window threshold at limit and limit+1
  task automatic testWindow(input logic [2:0] thr, input int e1, input int e2, input int lim,
                            input string tag);
    doReset(3'd0, thr);
    runTo(100);
    for (int i = 0; i < e1; i++) step(1'b1);
    runTo(1095);
    chk({tag, " window1"}, syncOk, (e1 <= lim) ? 1 : 0);
    if (e1 <= lim) begin
      runTo(1200);
      for (int i = 0; i < e2; i++) step(1'b1);
      runTo(2118);
      chk({tag, " pre boundary"}, syncOk, 1);
      step(1'b0);
      chk({tag, " window2"}, syncOk, (e2 <= lim) ? 1 : 0);
    end
  endtask

  // R9: saturation of bit counter
  task automatic testSaturate();
    doReset(3'd0, 3'd7);
    runTo(71 + 4200);
    step(1'b0, 1'b0, 1'b1);
    chk("R9 saturated bits", bitCount, 4095);
    chk("R9 errors zero", errCount, 0);
  endtask

  // R10: clear and latch in the same cycle on an errored bit
  task automatic testClearLatch();
    doReset(3'd0, 3'd7);
    runTo(100); step(1'b1);
    runTo(110); step(1'b1);
    runTo(200);
    step(1'b1, 1'b1, 1'b1);
    chk("R10 latch pre-clear bits", bitCount, 129);
    chk("R10 latch pre-clear errs", errCount, 2);
    runTo(250); step(1'b1);
    runTo(300);
    step(1'b0, 1'b0, 1'b1);
    chk("R10 bits after clear", bitCount, 99);
    chk("R10 errs after clear", errCount, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    finishRun();
  end

  initial begin
    @(negedge clk);
    testReset();
    testOrders();
    testVerifyAbort();
    testClassify();
    testWindow(3'd0, 10, 11, 10, "R7 k2");
    testWindow(3'd1, 1, 2, 1, "R7 k3");
    testWindow(3'd6, 0, 1, 0, "R7 k8");
    testWindow(3'd7, 256, 257, 256, "R8 auto");
    testSaturate();
    testClearLatch();
    finishRun();
  end

endmodule